// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block keeps a set of sticky status flags that tell a small processor core why it last restarted or woke. It watches single-cycle event strobes: power-on, brown-out, external master-clear, watchdog time-out, stack overflow, stack underflow, software reset instruction and interrupt wake-up. It also sees the current power mode and a stack-reset enable. Each event sets, clears or leaves alone every flag by its own rule, and several rules depend on the power mode.

One clock after an accepted event the block pulses `evt_valid`. With the pulse it reports whether the event was a full reset or a wake-up, and the program counter the core should continue from. A reset always restarts at address zero. A wake-up resumes at the current PC plus two, or at an interrupt vector. Software can write any flag back to one through a write-one-to-set port, so that the next cause can be told apart from the last one.

Top module: `rst_cause_tracker`

## Requirements
- R1: Flag vector bit order is [0] power-on, [1] brown-out, [2] timeout, [3] powerdown, [4] reset-instruction, [5] config-mismatch, [6] stack-full, [7] stack-underflow. A power-on event loads 8'h3C (bits 2..5 set, all others clear). It is a reset to 0, and it loads `sbor_en` from `sw_bor_cfg`.
- R2: A brown-out sets bits 2..5 and clears bit 1. It leaves bits 0, 6 and 7 alone and is a reset to 0.
- R3: Power mode encoding is 0 full run, 1 low-power run, 2 idle, 3 sleep. A master-clear always resets to 0. In mode 0 it changes no flag. In mode 1 it sets timeout. In mode 2 or 3 it sets timeout and clears powerdown.
- R4: A watchdog time-out in mode 0 or 1 clears only timeout and resets to 0. In mode 2 or 3 it is a wake-up that clears timeout and powerdown and resumes at `cur_pc`+2.
- R5: An interrupt wake in mode 1, 2 or 3 clears only powerdown and is a wake-up. If `gie_hi` is set it goes to 008h. Otherwise, if `gie_lo` is set, it goes to 018h. Otherwise it goes to `cur_pc`+2. In mode 0 the interrupt wake is ignored: no pulse and no flag change.
- R6: With `stk_rst_en`=1, an overflow sets stack-full and resets to 0. If no overflow is present, an underflow sets stack-underflow and resets to 0. With `stk_rst_en`=0, an overflow is ignored, and an underflow sets stack-underflow without a pulse.
- R7: A software reset instruction clears only reset-instruction and resets to 0.
- R8: Only the highest-priority event present acts. The order is power-on, brown-out, master-clear, watchdog, stack, software instruction, interrupt.
- R9: When `wr_en` is high, each bit set in `wr_set` sets the matching flag to 1. A same-cycle event's rule then applies on top of the written value.
- R10: Flags and outputs change on the clock edge after the inputs. `evt_valid` is high only in the cycle after an accepted event. With no event and no write, the flags hold.
- R11: While `rst_n` is low, the flags read 8'h3C, `sbor_en` reads 0 and `evt_valid` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low register initialisation |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_mclr | input | 1 | External master-clear strobe |
| ev_wdt | input | 1 | Watchdog time-out strobe |
| ev_stk_ovf | input | 1 | Stack overflow strobe |
| ev_stk_unf | input | 1 | Stack underflow strobe |
| ev_swrst | input | 1 | Software reset instruction strobe |
| ev_irq_wake | input | 1 | Interrupt wake-up strobe |
| pwr_mode | input | 2 | Current power mode |
| stk_rst_en | input | 1 | Stack error causes reset |
| sw_bor_cfg | input | 1 | Software brown-out configuration selected |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| cur_pc | input | PC_W | Current program counter |
| wr_en | input | 1 | Software flag write strobe |
| wr_set | input | 8 | Flags to set to one |
| flags | output | 8 | Sticky status flags |
| sbor_en | output | 1 | Software brown-out enable bit |
| evt_valid | output | 1 | Accepted event pulse |
| evt_is_reset | output | 1 | Accepted event was a reset (0 = wake-up) |
| next_pc | output | PC_W | Restart or resume address |

## Verification
The bench begins with directed runs of each event through every power mode. These separate the four mode-dependent outcomes of master-clear and watchdog, and the three vector choices of an interrupt wake. Further directed runs try the stack events with the enable both ways and an interrupt in full-run mode, which must leave the flags and the pulse untouched. Random cycles then mix sparse and clustered strobes with flag writes, so same-cycle collisions show whether priority picks the right event and whether a write lands before the event rule.

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker #(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_por,
  input  logic            ev_bor,
  input  logic            ev_mclr,
  input  logic            ev_wdt,
  input  logic            ev_stk_ovf,
  input  logic            ev_stk_unf,
  input  logic            ev_swrst,
  input  logic            ev_irq_wake,
  input  logic [1:0]      pwr_mode,
  input  logic            stk_rst_en,
  input  logic            sw_bor_cfg,
  input  logic            gie_hi,
  input  logic            gie_lo,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            wr_en,
  input  logic [7:0]      wr_set,
  output logic [7:0]      flags,
  output logic            sbor_en,
  output logic            evt_valid,
  output logic            evt_is_reset,
  output logic [PC_W-1:0] next_pc
);
  localparam int F_PWR = 0, F_BRN = 1, F_TMO = 2, F_PDN = 3;
  localparam int F_RIN = 4, F_CFG = 5, F_OVF = 6, F_UNF = 7;
  localparam logic [7:0] PWRUP = 8'h3C;
  localparam logic [PC_W-1:0] VEC_HI = PC_W'(8'h08);
  localparam logic [PC_W-1:0] VEC_LO = PC_W'(8'h18);

  wire mode_full = (pwr_mode == 2'd0);
  wire mode_lp   = pwr_mode[1];
  wire ovf_act   = ev_stk_ovf & stk_rst_en;
  wire stk_act   = ovf_act | ev_stk_unf;
  wire irq_act   = ev_irq_wake & ~mode_full;
  wire above_wdt = ev_por | ev_bor | ev_mclr;
  wire above_stk = above_wdt | ev_wdt;
  wire above_sw  = above_stk | stk_act;
  wire above_irq = above_sw | ev_swrst;

  wire [7:0] base = wr_en ? (flags | wr_set) : flags;
  wire [PC_W-1:0] resume_pc = cur_pc + PC_W'(2);

  logic [7:0]      nf;
  logic            n_valid, n_reset;
  logic [PC_W-1:0] n_pc;

  always_comb begin
    nf      = base;
    n_valid = 1'b1;
    n_reset = 1'b1;
    n_pc    = '0;
    if (ev_por) begin
      nf = PWRUP;
    end else if (ev_bor) begin
      nf[F_CFG] = 1'b1; nf[F_RIN] = 1'b1; nf[F_TMO] = 1'b1; nf[F_PDN] = 1'b1;
      nf[F_BRN] = 1'b0;
    end else if (ev_mclr) begin
      if (!mode_full) nf[F_TMO] = 1'b1;
      if (mode_lp)    nf[F_PDN] = 1'b0;
    end else if (ev_wdt) begin
      nf[F_TMO] = 1'b0;
      if (mode_lp) begin
        nf[F_PDN] = 1'b0;
        n_reset   = 1'b0;
        n_pc      = resume_pc;
      end
    end else if (stk_act) begin
      if (ovf_act) nf[F_OVF] = 1'b1;
      else begin
        nf[F_UNF] = 1'b1;
        n_valid   = stk_rst_en;
      end
    end else if (ev_swrst) begin
      nf[F_RIN] = 1'b0;
    end else if (irq_act) begin
      nf[F_PDN] = 1'b0;
      n_reset   = 1'b0;
      n_pc      = gie_hi ? VEC_HI : (gie_lo ? VEC_LO : resume_pc);
    end else begin
      n_valid = 1'b0;
      n_reset = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags        <= PWRUP;
      sbor_en      <= 1'b0;
      evt_valid    <= 1'b0;
      evt_is_reset <= 1'b0;
      next_pc      <= '0;
    end else begin
      flags        <= nf;
      evt_valid    <= n_valid;
      evt_is_reset <= n_valid & n_reset;
      next_pc      <= n_pc;
      if (ev_por) sbor_en <= sw_bor_cfg;
    end
  end

  wire any_ev = ev_por | ev_bor | ev_mclr | ev_wdt | ev_stk_ovf | ev_stk_unf | ev_swrst | ev_irq_wake;

  assert_por_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> (flags == PWRUP) && evt_valid && evt_is_reset && (next_pc == '0));
  assert_bor_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por) |=> !flags[F_BRN] && flags[F_TMO] && evt_is_reset);
  assert_wdt_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt && !above_wdt && pwr_mode[1]) |=> evt_valid && !evt_is_reset && !flags[F_TMO] && !flags[F_PDN]);
  assert_swrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_swrst && !above_sw) |=> !flags[F_RIN] && evt_is_reset);
  assert_reset_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_is_reset |-> evt_valid && (next_pc == '0));
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ev && !wr_en) |=> !evt_valid && $stable(flags));
  assert_irq_full_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_irq_wake && mode_full && !above_irq && !wr_en) |=> !evt_valid && $stable(flags));
endmodule

// File: tb/rst_cause_tracker_tb.sv
module rst_cause_tracker_tb;
  localparam int PC_W = 21;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ev = '0;
  logic [1:0] pwr_mode = '0;
  logic stk_rst_en = 1'b0, sw_bor_cfg = 1'b0, gie_hi = 1'b0, gie_lo = 1'b0, wr_en = 1'b0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [7:0] wr_set = '0;
  logic [7:0] flags;
  logic sbor_en, evt_valid, evt_is_reset;
  logic [PC_W-1:0] next_pc;

  int errors = 0, checks = 0;
  logic [7:0] e_flags;
  logic e_sbor, e_valid, e_reset;
  logic [PC_W-1:0] e_pc;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ev bits: 0 por, 1 bor, 2 mclr, 3 wdt, 4 ovf, 5 unf, 6 swrst, 7 irq
  rst_cause_tracker #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_por(ev[0]), .ev_bor(ev[1]), .ev_mclr(ev[2]), .ev_wdt(ev[3]),
    .ev_stk_ovf(ev[4]), .ev_stk_unf(ev[5]), .ev_swrst(ev[6]), .ev_irq_wake(ev[7]),
    .pwr_mode(pwr_mode), .stk_rst_en(stk_rst_en), .sw_bor_cfg(sw_bor_cfg),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .cur_pc(cur_pc), .wr_en(wr_en), .wr_set(wr_set),
    .flags(flags), .sbor_en(sbor_en), .evt_valid(evt_valid),
    .evt_is_reset(evt_is_reset), .next_pc(next_pc));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model of the next state, written from the requirements
  task automatic predict();
    logic [7:0] f;
    int n;
    f = wr_en ? (e_flags | wr_set) : e_flags;
    e_valid = 1'b1; e_reset = 1'b1; e_pc = '0;
    n = $countones({ev[7] && pwr_mode != 0, ev[6], ev[5] || (ev[4] && stk_rst_en), ev[3], ev[2], ev[1], ev[0]});
    if (ev[0]) begin f = 8'h3C; e_sbor = sw_bor_cfg; tag = "R1"; end
    else if (ev[1]) begin f[5:2] = 4'hF; f[1] = 1'b0; tag = "R2"; end
    else if (ev[2]) begin
      tag = "R3";
      if (pwr_mode == 1) f[2] = 1'b1;
      if (pwr_mode >= 2) begin f[2] = 1'b1; f[3] = 1'b0; end
    end else if (ev[3]) begin
      tag = "R4"; f[2] = 1'b0;
      if (pwr_mode >= 2) begin f[3] = 1'b0; e_reset = 1'b0; e_pc = cur_pc + 2; end
    end else if (ev[4] && stk_rst_en) begin f[6] = 1'b1; tag = "R6"; end
    else if (ev[5]) begin f[7] = 1'b1; e_valid = stk_rst_en; e_reset = stk_rst_en; tag = "R6"; end
    else if (ev[6]) begin f[4] = 1'b0; tag = "R7"; end
    else if (ev[7] && pwr_mode != 0) begin
      tag = "R5"; f[3] = 1'b0; e_reset = 1'b0;
      e_pc = gie_hi ? PC_W'(8'h08) : gie_lo ? PC_W'(8'h18) : cur_pc + 2;
    end else begin
      e_valid = 1'b0; e_reset = 1'b0;
      tag = ev[7] ? "R5" : (wr_en ? "R9" : "R10");
    end
    if (n > 1) tag = "R8";
    e_flags = f;
  endtask

  task automatic step(input logic [7:0] e, input logic [1:0] m, input logic en, input logic cfg,
                      input logic gh, input logic gl, input logic [PC_W-1:0] pc,
                      input logic we, input logic [7:0] ws);
    ev = e; pwr_mode = m; stk_rst_en = en; sw_bor_cfg = cfg; gie_hi = gh; gie_lo = gl;
    cur_pc = pc; wr_en = we; wr_set = ws;
    predict();
    @(negedge clk);
    chk(tag, "flags", 32'(flags), 32'(e_flags));
    chk(tag, "evt_valid", 32'(evt_valid), 32'(e_valid));
    chk(tag, "sbor_en", 32'(sbor_en), 32'(e_sbor));
    if (e_valid) begin
      chk(tag, "evt_is_reset", 32'(evt_is_reset), 32'(e_reset));
      chk(tag, "next_pc", 32'(next_pc), 32'(e_pc));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    e_flags = 8'h3C; e_sbor = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11", "flags", 32'(flags), 32'h3C);
    chk("R11", "sbor_en", 32'(sbor_en), 32'h0);
    chk("R11", "evt_valid", 32'(evt_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step(8'h01, 0, 1, 1, 0, 0, 21'h100, 0, 0);        // R1 power-on, sbor_en loads 1
    step(8'h00, 0, 1, 0, 0, 0, 21'h100, 0, 0);        // R10 quiet hold
    step(8'h40, 0, 1, 0, 0, 0, 21'h100, 0, 0);        // R7
    step(8'h00, 0, 1, 0, 0, 0, 21'h100, 1, 8'hFF);    // R9 write all ones
    step(8'h02, 0, 1, 0, 0, 0, 21'h100, 0, 0);        // R2
    for (int m = 0; m < 4; m++) begin
      step(8'h00, 0, 1, 0, 0, 0, 0, 1, 8'h0C);
      step(8'h04, 2'(m), 1, 0, 0, 0, 21'h200, 0, 0);  // R3 per mode
      step(8'h08, 2'(m), 1, 0, 0, 0, 21'h3FE, 0, 0);  // R4 per mode
      step(8'h80, 2'(m), 1, 0, 0, 0, 21'h124, 0, 0);  // R5 pc+2 or ignored
    end
    step(8'h80, 3, 1, 0, 1, 1, 21'h50, 0, 0);         // R5 high vector
    step(8'h80, 2, 1, 0, 0, 1, 21'h50, 0, 0);         // R5 low vector
    step(8'h10, 0, 0, 0, 0, 0, 21'h50, 0, 0);         // R6 overflow ignored
    step(8'h20, 0, 0, 0, 0, 0, 21'h50, 0, 0);         // R6 underflow no pulse
    step(8'h30, 0, 1, 0, 0, 0, 21'h50, 0, 0);         // R6 overflow wins
    step(8'h48, 0, 1, 0, 0, 0, 21'h50, 1, 8'h10);     // R8 wdt beats swrst
    step(8'h06, 3, 1, 0, 0, 0, 21'h50, 0, 0);         // R8 bor beats mclr
    step(8'h05, 1, 1, 0, 0, 0, 21'h50, 0, 0);         // R8 por beats mclr, sbor_en -> 0
    step(8'h40, 0, 1, 0, 0, 0, 21'h50, 1, 8'hFF);     // R9 write then event rule
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e;
      e = '0;
      for (int b = 0; b < 8; b++) e[b] = (($urandom % (b == 0 ? 40 : 9)) == 0);
      step(e, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           PC_W'($urandom), (($urandom % 5) == 0), 8'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule